// File: doc/BRIEF.md
# Byte-Stream Frame Aligner with Loss Alarms

This block sits right after an 8:1 deserializer on a SONET/SDH receive line. The deserializer's byte boundary is arbitrary, so the incoming bytes can carry the line bits at any of eight bit shifts. The block watches a 40-bit window of the raw stream for a 32-bit framing word. That word is the last two A1 bytes (0xF6) followed by the first two A2 bytes (0x28). The block checks it at all eight bit shifts. Once a shift is confirmed, it re-cuts the stream into frame-aligned bytes. It then drives a frame-start strobe and row and column indices for every aligned byte.

Three alarms are kept. Out of frame tracks the framing word at its expected place. Loss of frame integrates out of frame over whole frame periods. Loss of signal watches for a long run of all-zero input bytes. While loss of signal or loss of frame is high, the aligned output is overridden with all ones (line AIS). A control input can switch on a frame-synchronous descrambler with polynomial x^7+x^6+1. The descrambler leaves the first-row overhead bytes untouched.

Top module: `sfa_frame_aligner`

## Requirements
- R1: After reset, `oof` is 1, `lof` and `los` are 0 and `frame_start` is 0.
- R2: The framing word F6 F6 28 28 (bits sent MSB first) is found at any of the eight bit shifts. A first sighting followed by a second sighting exactly one frame later clears `oof`. After only the first sighting, `oof` stays 1.
- R3: While in frame, `aligned_byte` carries the stream re-cut on the locked shift. `frame_start` pulses with the first A1 byte, which is frame byte 0. For frame byte i, `row_idx` = i / ROW_BYTES and `col_idx` = i mod ROW_BYTES. A1 occupies bytes 0..NUM_A1-1 and A2 occupies the following NUM_A1 bytes.
- R4: While in frame, the framing word is checked only at its expected place. A copy of the word elsewhere in the payload changes neither the shift, the strobe position nor `oof`.
- R5: Four consecutive frames whose framing word is wrong set `oof`. Three wrong frames followed by a correct one leave `oof` at 0.
- R6: `lof` rises after `oof` has stayed high for 24 frame periods, never before 23. It falls after `oof` has stayed low for 24 frame periods.
- R7: `los` rises on the clock edge that samples the LOS_BYTES-th consecutive 0x00 input byte, and not one byte earlier. It falls once two consecutive correct framing words have been seen.
- R8: While `los` or `lof` is 1, `aligned_byte` is 0xFF.
- R9: With `descr_en` = 1, every aligned byte outside the first-row overhead is XORed with the x^7+x^6+1 sequence. The first-row overhead is bytes 0..3*NUM_A1-1. The sequence is reloaded with all ones after the last first-row overhead byte, and its first output bit is the byte's MSB. With `descr_en` = 0, bytes pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Raw deserializer byte, earliest bit in bit 7 |
| descr_en | input | 1 | Enables descrambling of non-overhead bytes |
| aligned_byte | output | 8 | Frame-aligned, optionally descrambled byte; 0xFF under AIS |
| frame_start | output | 1 | High with frame byte 0 while in frame |
| row_idx | output | ROW_W | Row of the current aligned byte |
| col_idx | output | COL_W | Column of the current aligned byte |
| oof | output | 1 | Out of frame |
| lof | output | 1 | Loss of frame |
| los | output | 1 | Loss of signal |

## Verification
The hardest cases to reach are the loss-of-frame edges, because they depend on the out-of-frame state lasting whole frame periods. The bench first locks the block. It then feeds frames with a broken A1 run until four misses set out of frame. It keeps feeding broken frames and samples `lof` once before the 24-frame window ends and once after it. Recovery is checked the same way with clean frames. A second, non-zero bit shift and a payload that carries a stray copy of the framing word confirm that the locked shift, and not a later sighting, drives the alignment.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

  localparam logic [31:0] SYNC_WORD = 32'hF6F6_2828;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCK    = 2'd2
  } align_state_e;

  // 32-bit word starting k bits below the oldest bit of the window
  function automatic logic [31:0] word_at(input logic [39:0] win, input logic [2:0] k);
    logic [39:0] sh;
    sh = win << k;
    return sh[39:8];
  endfunction

  // byte starting k bits below the oldest bit of the window
  function automatic logic [7:0] byte_at(input logic [39:0] win, input logic [2:0] k);
    logic [39:0] sh;
    sh = win << k;
    return sh[39:32];
  endfunction

  // eight keystream bits, first bit in the MSB
  function automatic logic [7:0] key_byte(input logic [6:0] st);
    logic [7:0] kb;
    logic [6:0] s;
    s = st;
    for (int i = 7; i >= 0; i--) begin
      kb[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    return kb;
  endfunction

  function automatic logic [6:0] key_next(input logic [6:0] st);
    logic [6:0] s;
    s = st;
    for (int i = 0; i < 8; i++) s = {s[5:0], s[6] ^ s[5]};
    return s;
  endfunction

endpackage

// File: rtl/sfa_bit_window.sv
module sfa_bit_window
  import sfa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_byte,
  input  logic [2:0] sel_off,
  output logic       hit_any,
  output logic [2:0] hit_off,
  output logic       sel_match,
  output logic [7:0] sel_byte
);

  logic [39:0] win_q;
  logic [7:0]  hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= {win_q[31:0], rx_byte};
  end

  for (genvar k = 0; k < 8; k++) begin : g_shift
    assign hit_vec[k] = (word_at(win_q, 3'(k)) == SYNC_WORD);
  end

  // lowest shift wins when several match
  always_comb begin
    hit_off = '0;
    for (int k = 7; k >= 0; k--) begin
      if (hit_vec[k]) hit_off = 3'(k);
    end
  end

  assign hit_any   = |hit_vec;
  assign sel_match = hit_vec[sel_off];
  assign sel_byte  = byte_at(win_q, sel_off);

endmodule

// File: rtl/sfa_frame_ctrl.sv
module sfa_frame_ctrl
  import sfa_pkg::*;
#(
  parameter int ROW_BYTES  = 270,
  parameter int ROWS       = 9,
  parameter int NUM_A1     = 3,
  parameter int MISS_LIMIT = 4,
  localparam int COL_W = $clog2(ROW_BYTES),
  localparam int ROW_W = $clog2(ROWS),
  localparam int MW    = (MISS_LIMIT > 2) ? $clog2(MISS_LIMIT) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_any,
  input  logic [2:0]       hit_off,
  input  logic             sel_match,
  output logic [2:0]       sel_off,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic             locked,
  output logic             good_evt,
  output logic             miss_evt
);

  localparam logic [COL_W-1:0] CHK_COL  = COL_W'(NUM_A1 - 2);
  localparam logic [COL_W-1:0] NXT_COL  = COL_W'(NUM_A1 - 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_BYTES - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [MW-1:0]    LAST_MISS = MW'(MISS_LIMIT - 1);

  align_state_e     st_q, st_d;
  logic [2:0]       off_q, off_d;
  logic [MW-1:0]    miss_q, miss_d;
  logic [ROW_W-1:0] row_d, row_nx;
  logic [COL_W-1:0] col_d, col_nx;
  logic             at_check;

  assign at_check = (row_q == '0) && (col_q == CHK_COL);

  always_comb begin
    col_nx = col_q + 1'b1;
    row_nx = row_q;
    if (col_q == LAST_COL) begin
      col_nx = '0;
      row_nx = (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
    end
  end

  always_comb begin
    st_d     = st_q;
    off_d    = off_q;
    miss_d   = miss_q;
    row_d    = row_nx;
    col_d    = col_nx;
    good_evt = 1'b0;
    miss_evt = 1'b0;
    unique case (st_q)
      ST_SEARCH: begin
        if (hit_any) begin
          st_d     = ST_CONFIRM;
          off_d    = hit_off;
          row_d    = '0;
          col_d    = NXT_COL;
          miss_d   = '0;
          good_evt = 1'b1;
        end
      end
      ST_CONFIRM: begin
        if (at_check) begin
          if (sel_match) begin
            st_d     = ST_LOCK;
            good_evt = 1'b1;
          end else begin
            st_d     = ST_SEARCH;
            miss_evt = 1'b1;
          end
        end
      end
      ST_LOCK: begin
        if (at_check) begin
          if (sel_match) begin
            miss_d   = '0;
            good_evt = 1'b1;
          end else begin
            miss_evt = 1'b1;
            if (miss_q == LAST_MISS) begin
              st_d   = ST_SEARCH;
              miss_d = '0;
            end else begin
              miss_d = miss_q + 1'b1;
            end
          end
        end
      end
      default: st_d = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_SEARCH;
      off_q  <= '0;
      miss_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      st_q   <= st_d;
      off_q  <= off_d;
      miss_q <= miss_d;
      row_q  <= row_d;
      col_q  <= col_d;
    end
  end

  assign sel_off = off_q;
  assign locked  = (st_q == ST_LOCK);

  assert_offset_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (!locked || $stable(sel_off)));

  assert_oof_after_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(miss_evt));

  assert_col_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= LAST_COL);

endmodule

// File: rtl/sfa_alarm.sv
module sfa_alarm #(
  parameter int FRAME_BYTES = 2430,
  parameter int LOS_BYTES   = 389,
  parameter int LOF_FRAMES  = 24,
  localparam int PW = $clog2(FRAME_BYTES),
  localparam int ZW = $clog2(LOS_BYTES + 1),
  localparam int FW = $clog2(LOF_FRAMES + 1)
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_byte,
  input  logic       oof,
  input  logic       good_evt,
  input  logic       miss_evt,
  output logic       los,
  output logic       lof
);

  localparam logic [PW-1:0] LAST_P = PW'(FRAME_BYTES - 1);
  localparam logic [ZW-1:0] LAST_Z = ZW'(LOS_BYTES - 1);
  localparam logic [FW-1:0] LAST_F = FW'(LOF_FRAMES - 1);

  logic [PW-1:0] per_q;
  logic [ZW-1:0] zero_q;
  logic [FW-1:0] frm_q;
  logic [1:0]    good_q;
  logic          tick;

  assign tick = (per_q == LAST_P);

  always_ff @(posedge clk) begin
    if (!rst_n) per_q <= '0;
    else        per_q <= tick ? '0 : per_q + 1'b1;
  end

  // loss of signal: zero-run counter, cleared by two good framing words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_q <= '0;
      good_q <= '0;
      los    <= 1'b0;
    end else begin
      if (rx_byte != 8'h00)      zero_q <= '0;
      else if (zero_q != LAST_Z) zero_q <= zero_q + 1'b1;

      if (rx_byte == 8'h00 && zero_q == LAST_Z) begin
        los    <= 1'b1;
        good_q <= '0;
      end else if (los) begin
        if (miss_evt) good_q <= '0;
        else if (good_evt) begin
          if (good_q == 2'd1) begin
            los    <= 1'b0;
            good_q <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
      end
    end
  end

  // loss of frame: integrate the out-of-frame state over frame periods
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_q <= '0;
      lof   <= 1'b0;
    end else if (oof == lof) begin
      frm_q <= '0;
    end else if (tick) begin
      if (frm_q == LAST_F) begin
        lof   <= ~lof;
        frm_q <= '0;
      end else begin
        frm_q <= frm_q + 1'b1;
      end
    end
  end

  assert_los_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(rx_byte == 8'h00));

  assert_lof_needs_oof_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof) |-> $past(oof));

endmodule

// File: rtl/sfa_descrambler.sv
module sfa_descrambler
  import sfa_pkg::*;
#(
  parameter int ROW_W    = 4,
  parameter int COL_W    = 9,
  parameter int OH_BYTES = 9
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             descr_en,
  input  logic [7:0]       in_byte,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic [7:0]       out_byte
);

  localparam logic [COL_W-1:0] OH_LAST = COL_W'(OH_BYTES - 1);

  logic [6:0] lfsr_q;
  logic       in_oh, oh_end;

  assign in_oh  = (row == '0) && (col <= OH_LAST);
  assign oh_end = (row == '0) && (col == OH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      lfsr_q <= 7'h7F;
    else if (oh_end) lfsr_q <= 7'h7F;
    else if (!in_oh) lfsr_q <= key_next(lfsr_q);
  end

  assign out_byte = (descr_en && !in_oh) ? (in_byte ^ key_byte(lfsr_q)) : in_byte;

endmodule

// File: rtl/sfa_frame_aligner.sv
module sfa_frame_aligner #(
  parameter int ROW_BYTES  = 270,
  parameter int ROWS       = 9,
  parameter int NUM_A1     = 3,
  parameter int LOS_BYTES  = 389,
  parameter int MISS_LIMIT = 4,
  parameter int LOF_FRAMES = 24,
  localparam int COL_W = $clog2(ROW_BYTES),
  localparam int ROW_W = $clog2(ROWS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_byte,
  input  logic             descr_en,
  output logic [7:0]       aligned_byte,
  output logic             frame_start,
  output logic [ROW_W-1:0] row_idx,
  output logic [COL_W-1:0] col_idx,
  output logic             oof,
  output logic             lof,
  output logic             los
);

  localparam int FRAME_BYTES = ROW_BYTES * ROWS;
  localparam int OH_BYTES    = 3 * NUM_A1;

  logic             hit_any, sel_match, locked, good_evt, miss_evt;
  logic [2:0]       hit_off, sel_off;
  logic [7:0]       sel_byte, plain_byte, data_q;
  logic [ROW_W-1:0] row_cur;
  logic [COL_W-1:0] col_cur;

  sfa_bit_window u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_byte   (rx_byte),
    .sel_off   (sel_off),
    .hit_any   (hit_any),
    .hit_off   (hit_off),
    .sel_match (sel_match),
    .sel_byte  (sel_byte)
  );

  sfa_frame_ctrl #(
    .ROW_BYTES (ROW_BYTES),
    .ROWS      (ROWS),
    .NUM_A1    (NUM_A1),
    .MISS_LIMIT(MISS_LIMIT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_any   (hit_any),
    .hit_off   (hit_off),
    .sel_match (sel_match),
    .sel_off   (sel_off),
    .row_q     (row_cur),
    .col_q     (col_cur),
    .locked    (locked),
    .good_evt  (good_evt),
    .miss_evt  (miss_evt)
  );

  sfa_descrambler #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .OH_BYTES (OH_BYTES)
  ) u_descr (
    .clk      (clk),
    .rst_n    (rst_n),
    .descr_en (descr_en),
    .in_byte  (sel_byte),
    .row      (row_cur),
    .col      (col_cur),
    .out_byte (plain_byte)
  );

  sfa_alarm #(
    .FRAME_BYTES (FRAME_BYTES),
    .LOS_BYTES   (LOS_BYTES),
    .LOF_FRAMES  (LOF_FRAMES)
  ) u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_byte  (rx_byte),
    .oof      (oof),
    .good_evt (good_evt),
    .miss_evt (miss_evt),
    .los      (los),
    .lof      (lof)
  );

  assign oof = ~locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q      <= '0;
      frame_start <= 1'b0;
      row_idx     <= '0;
      col_idx     <= '0;
    end else begin
      data_q      <= plain_byte;
      frame_start <= locked && (row_cur == '0) && (col_cur == '0);
      row_idx     <= row_cur;
      col_idx     <= col_cur;
    end
  end

  assign aligned_byte = (los || lof) ? 8'hFF : data_q;

  assert_strobe_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (row_idx == '0 && col_idx == '0));

  assert_oof_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof) |-> $past(good_evt));

  assert_ais_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (los && $past(los)) |-> $stable(aligned_byte));

endmodule

// File: tb/sfa_frame_aligner_bench.sv
module sfa_frame_aligner_bench;

  localparam int ROWB = 12;
  localparam int NROW = 9;
  localparam int NA1  = 3;
  localparam int FR   = ROWB * NROW;
  localparam int OH   = 3 * NA1;
  localparam int LOSB = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx = 8'h00;
  logic       den = 1'b0;
  logic [7:0] ab;
  logic       fs, oof, lof, los;
  logic [3:0] row;
  logic [3:0] col;

  always #10 clk = ~clk;

  sfa_frame_aligner #(
    .ROW_BYTES (ROWB),
    .ROWS      (NROW),
    .NUM_A1    (NA1),
    .LOS_BYTES (LOSB)
  ) u_sfa_frame_aligner (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_byte      (rx),
    .descr_en     (den),
    .aligned_byte (ab),
    .frame_start  (fs),
    .row_idx      (row),
    .col_idx      (col),
    .oof          (oof),
    .lof          (lof),
    .los          (los)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] plain [FR];
  logic [7:0] keyb  [FR];
  int   shift = 0;
  logic [7:0] prev = 8'h00;
  bit   cmp_arm = 0, cmp_act = 0, cmp_done = 0;
  int   cmp_idx = 0;
  string cmp_tag = "R3";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [7:0] b);
    rx = b;
    @(posedge clk);
    @(negedge clk);
    if (cmp_arm && !cmp_act && fs) begin
      cmp_act = 1;
      cmp_idx = 0;
    end
    if (cmp_act) begin
      chk(ab == plain[cmp_idx], cmp_tag, ab, plain[cmp_idx]);
      chk(row == 4'(cmp_idx / ROWB), "R3 row", row, cmp_idx / ROWB);
      chk(col == 4'(cmp_idx % ROWB), "R3 col", col, cmp_idx % ROWB);
      cmp_idx++;
      if (cmp_idx == FR) begin
        cmp_act  = 0;
        cmp_arm  = 0;
        cmp_done = 1;
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [15:0] pair;
    pair = {prev, b};
    prev = b;
    tick(8'(pair >> shift));
  endtask

  // kind 0: clean, 1: broken A1 run, 2: stray framing word in payload
  task automatic send_frame(input int kind, input bit scr);
    logic [7:0] b;
    for (int i = 0; i < FR; i++) begin
      b = plain[i];
      if (kind == 1 && i < NA1) b = 8'h55;
      if (kind == 2 && i == 50) b = 8'hF6;
      if (kind == 2 && i == 51) b = 8'hF6;
      if (kind == 2 && i == 52) b = 8'h28;
      if (kind == 2 && i == 53) b = 8'h28;
      if (scr && i >= OH) b = b ^ keyb[i];
      send_byte(b);
    end
  endtask

  task automatic do_reset(input int sh, input bit d);
    rst_n = 1'b0;
    den   = d;
    shift = sh;
    prev  = 8'h00;
    for (int i = 0; i < 3; i++) tick(8'h00);
    rst_n = 1'b1;
  endtask

  task automatic compare_frames(input bit scr, input string tag);
    cmp_tag  = tag;
    cmp_done = 0;
    cmp_arm  = 1;
    for (int f = 0; f < 3; f++) send_frame(0, scr);
    chk(cmp_done, {tag, " frame captured"}, cmp_done, 1);
  endtask

  task automatic test_reset;
    do_reset(0, 0);
    chk(oof == 1'b1, "R1 oof", oof, 1);
    chk(lof == 1'b0, "R1 lof", lof, 0);
    chk(los == 1'b0, "R1 los", los, 0);
    chk(fs == 1'b0, "R1 frame_start", fs, 0);
  endtask

  task automatic test_lock(input int sh);
    do_reset(sh, 0);
    send_frame(0, 0);
    chk(oof == 1'b1, "R2 one sighting", oof, 1);
    send_frame(0, 0);
    chk(oof == 1'b0, "R2 locked", oof, 0);
    compare_frames(0, "R3 aligned byte");
    chk(oof == 1'b0, "R9 disabled pass", oof, 0);
  endtask

  task automatic test_stray;
    send_frame(2, 0);
    chk(oof == 1'b0, "R4 oof", oof, 0);
    compare_frames(0, "R4 alignment kept");
  endtask

  task automatic test_oof;
    for (int f = 0; f < 3; f++) send_frame(1, 0);
    chk(oof == 1'b0, "R5 three misses", oof, 0);
    send_frame(0, 0);
    chk(oof == 1'b0, "R5 recovered", oof, 0);
    for (int f = 0; f < 3; f++) send_frame(1, 0);
    chk(oof == 1'b0, "R5 before fourth", oof, 0);
    send_frame(1, 0);
    chk(oof == 1'b1, "R5 fourth miss", oof, 1);
  endtask

  task automatic test_lof;
    for (int f = 0; f < 21; f++) send_frame(1, 0);
    chk(lof == 1'b0, "R6 early", lof, 0);
    for (int f = 0; f < 3; f++) send_frame(1, 0);
    chk(lof == 1'b1, "R6 set", lof, 1);
    for (int i = 0; i < 5; i++) begin
      send_byte(plain[OH + i]);
      chk(ab == 8'hFF, "R8 AIS on lof", ab, 8'hFF);
    end
    for (int i = 5; i < FR - OH; i++) send_byte(plain[OH + i]);
    for (int f = 0; f < 22; f++) send_frame(0, 0);
    chk(oof == 1'b0, "R6 oof cleared", oof, 0);
    chk(lof == 1'b1, "R6 hold", lof, 1);
    for (int f = 0; f < 6; f++) send_frame(0, 0);
    chk(lof == 1'b0, "R6 cleared", lof, 0);
  endtask

  task automatic test_los;
    do_reset(2, 0);
    for (int i = 0; i < LOSB - 1; i++) send_byte(8'h00);
    chk(los == 1'b0, "R7 one short", los, 0);
    send_byte(8'h00);
    chk(los == 1'b1, "R7 set", los, 1);
    chk(ab == 8'hFF, "R8 AIS on los", ab, 8'hFF);
    send_frame(0, 0);
    chk(los == 1'b1, "R7 one frame", los, 1);
    chk(ab == 8'hFF, "R8 AIS held", ab, 8'hFF);
    send_frame(0, 0);
    chk(los == 1'b0, "R7 cleared", los, 0);
  endtask

  task automatic test_descr;
    do_reset(3, 1);
    send_frame(0, 1);
    send_frame(0, 1);
    chk(oof == 1'b0, "R9 locked", oof, 0);
    compare_frames(1, "R9 descrambled");
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit kbits [(FR - OH) * 8];
    for (int n = 0; n < (FR - OH) * 8; n++)
      kbits[n] = (n < 7) ? 1'b1 : (kbits[n - 7] ^ kbits[n - 6]);
    for (int i = 0; i < FR; i++) begin
      keyb[i] = 8'h00;
      if (i < NA1)            plain[i] = 8'hF6;
      else if (i < 2 * NA1)   plain[i] = 8'h28;
      else                    plain[i] = 8'(8'h11 + 3 * i);
      if (i >= OH)
        for (int j = 0; j < 8; j++) keyb[i][7 - j] = kbits[(i - OH) * 8 + j];
    end
    @(negedge clk);
    test_reset();
    test_lock(0);
    test_lock(5);
    test_stray();
    test_oof();
    test_lof();
    test_los();
    test_descr();
    finish_run();
  end

endmodule